// File: doc/BRIEF.md
# Dual-Edge Selectable Up-Counter Pair

The block holds a set of small, independent up-counters. By default there are two, each 4 bits wide. Each counter has two count inputs, a count line and a gate line, and either one can serve as the trigger. A counter steps when the count line rises while the gate line is high. It also steps when the gate line falls while the count line is low. Wiring a signal to the count line (with the gate tied high) makes the counter step on that signal's positive edges. Wiring it to the gate line (with the count line tied low) makes it step on negative edges.

A parameter sets the modulus: 10 for decimal-digit counting or 16 for plain binary. Every bit of a counter changes on the same system-clock edge. A level-sensitive clear input resets each counter to zero.

Both count inputs are asynchronous. They pass through a two-stage synchronizer clocked by the fast system clock, and their edges are detected against the previous synchronized value. A pin change therefore shows at the output three system-clock edges later. Counters can be chained in ripple fashion: connect the top output bit of one counter to the gate line of the next, and hold that next counter's count line low. The next counter then steps each time the first one wraps.

Top module: `twin_edge_counter`

## Requirements
- R1: A rising count line while the synchronized gate line is high increments that counter by one. The new value appears on the third system-clock rising edge after the pin change.
- R2: A falling gate line while the synchronized count line is low increments that counter by one, with the same three-edge latency.
- R3: In every other case the counter holds its value. This covers a rising count line with the gate low, a falling gate with the count line high, a rising gate line, a falling count line and steady inputs.
- R4: While a counter's clear input is high, the counter reads 0 from the next system-clock edge on. No increment takes place during that time, even if a qualifying edge arrives.
- R5: With MOD = 10 the counter runs 0 through 9 and wraps from 9 to 0. It never shows a value above 9.
- R6: With MOD = 16 the counter runs 0 through 15 and wraps from 15 to 0.
- R7: The counters are independent. Stimulus or clear on one counter never changes another counter.
- R8: When a counter's gate line is driven from bit 3 of the previous counter's output and its count line is held low, it increments once each time the previous counter falls from a value with bit 3 set to a value with bit 3 clear.
- R9: While rst_n is low, all counters read 0. With both lines low, releasing reset produces no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all count inputs |
| rst_n | input | 1 | Active-low synchronous system reset |
| cnt_clk | input | CH | Count line, one bit per counter |
| cnt_en | input | CH | Gate line, one bit per counter |
| cnt_clr | input | CH | Level-sensitive clear, one bit per counter |
| cnt_q | output | CH*W | Counter values; counter i occupies bits [i*W +: W] |

## Verification
The directed patterns take a single counter through each pin transition in turn. This separates the two qualifying edges (R1, R2) from the four look-alikes that must not count (R3). The random phase toggles the count and gate lines of both counters, sometimes on the same cycle, and applies clears at random. It checks each result against a bench model, so a swapped gate polarity, a cross-coupled counter or a missed clear all show up (R7). Long pulse trains in both moduli reach the 9 and 15 wraps. A chained pair then shows whether the second stage steps exactly on each fall of the first counter's bit 3.

// File: rtl/twin_edge_counter.sv
module twin_edge_counter #(
  parameter int CH   = 2,
  parameter int W    = 4,
  parameter int MOD  = 10,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH-1:0]   cnt_clk,
  input  logic [CH-1:0]   cnt_en,
  input  logic [CH-1:0]   cnt_clr,
  output logic [CH*W-1:0] cnt_q
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [CH-1:0] step_v;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [SYNC-1:0] c_sy, e_sy;
    logic            c_d, e_d;
    logic [W-1:0]    q;
    logic            c_now, e_now;

    assign c_now = c_sy[SYNC-1];
    assign e_now = e_sy[SYNC-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_sy <= '0;
        e_sy <= '0;
        c_d  <= 1'b0;
        e_d  <= 1'b0;
      end else begin
        c_sy <= {c_sy[SYNC-2:0], cnt_clk[g]};
        e_sy <= {e_sy[SYNC-2:0], cnt_en[g]};
        c_d  <= c_now;
        e_d  <= e_now;
      end
    end

    assign step_v[g] = (c_now & ~c_d & e_now) | (e_d & ~e_now & ~c_now);

    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clr[g]) q <= '0;
      else if (step_v[g])       q <= (q >= TOP) ? '0 : q + 1'b1;
    end

    assign cnt_q[g*W +: W] = q;
  end
endmodule

// File: rtl/twin_edge_counter_chk.sv
module twin_edge_counter_chk #(
  parameter int CH  = 2,
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CH-1:0]   cnt_clr,
  input logic [CH-1:0]   step_v,
  input logic [CH*W-1:0] cnt_q
);
  function automatic logic [W-1:0] succ(logic [W-1:0] v);
    return (int'(v) + 1 >= MOD) ? '0 : W'(int'(v) + 1);
  endfunction

  for (genvar i = 0; i < CH; i++) begin : g_a
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr[i] |=> cnt_q[i*W +: W] == '0);
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_v[i] && !cnt_clr[i]) |=> cnt_q[i*W +: W] == succ($past(cnt_q[i*W +: W])));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_v[i] && !cnt_clr[i]) |=> $stable(cnt_q[i*W +: W]));
    if (MOD < (1 << W)) begin : g_rng
      assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q[i*W +: W]) < MOD);
    end
  end
endmodule

bind twin_edge_counter twin_edge_counter_chk #(.CH(CH), .W(W), .MOD(MOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .step_v(step_v), .cnt_q(cnt_q));

// File: tb/twin_edge_counter_bench.sv
`timescale 1ns/1ps
module twin_edge_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] c_drv = '0, e_drv = '0, clr = '0;
  logic       casc = 1'b0;
  logic [7:0] q_bcd, q_bin;
  logic [1:0] clk_bcd, en_bcd, clk_bin, en_bin;

  assign clk_bcd = casc ? {1'b0, c_drv[0]} : c_drv;
  assign clk_bin = clk_bcd;
  assign en_bcd  = casc ? {q_bcd[3], e_drv[0]} : e_drv;
  assign en_bin  = casc ? {q_bin[3], e_drv[0]} : e_drv;

  twin_edge_counter #(.MOD(10)) u_twin_edge_counter (
    .clk(clk), .rst_n(rst_n), .cnt_clk(clk_bcd), .cnt_en(en_bcd),
    .cnt_clr(clr), .cnt_q(q_bcd));
  twin_edge_counter #(.MOD(16)) u_twin_edge_counter_bin (
    .clk(clk), .rst_n(rst_n), .cnt_clk(clk_bin), .cnt_en(en_bin),
    .cnt_clr(clr), .cnt_q(q_bin));

  int checks = 0, fails = 0;
  int m_bcd [2];
  int m_bin [2];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(int v, int m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " dec ch0"}, int'(q_bcd[3:0]), m_bcd[0]);
    chk({tag, " dec ch1"}, int'(q_bcd[7:4]), m_bcd[1]);
    chk({tag, " bin ch0"}, int'(q_bin[3:0]), m_bin[0]);
    chk({tag, " bin ch1"}, int'(q_bin[7:4]), m_bin[1]);
  endtask

  task automatic apply(logic [1:0] nc, logic [1:0] ne, string tag);
    for (int i = 0; i < 2; i++) begin
      if (casc && i == 1) continue;
      if (clr[i]) begin
        m_bcd[i] = 0; m_bin[i] = 0;
      end else if ((!c_drv[i] && nc[i] && ne[i]) || (e_drv[i] && !ne[i] && !nc[i])) begin
        int ob = m_bcd[0], on = m_bin[0];
        m_bcd[i] = nxt(m_bcd[i], 10);
        m_bin[i] = nxt(m_bin[i], 16);
        if (casc && i == 0) begin
          if (ob >= 8 && m_bcd[0] < 8) m_bcd[1] = nxt(m_bcd[1], 10);
          if (on >= 8 && m_bin[0] < 8) m_bin[1] = nxt(m_bin[1], 16);
        end
      end
    end
    c_drv = nc; e_drv = ne;
    settle();
    check_all(tag);
  endtask

  task automatic pulse0(string tag);
    apply({c_drv[1], 1'b1}, {e_drv[1], 1'b1}, tag);
    apply({c_drv[1], 1'b0}, {e_drv[1], 1'b1}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2; i++) begin m_bcd[i] = 0; m_bin[i] = 0; end
    repeat (3) @(negedge clk);
    check_all("R9 in reset");
    rst_n = 1'b1;
    settle();
    check_all("R9 after release");

    // R1 / R2 / R3 directed on counter 0
    apply(2'b00, 2'b01, "R3 gate rise");
    apply(2'b01, 2'b01, "R1 count rise gate high");
    apply(2'b00, 2'b01, "R3 count fall");
    apply(2'b00, 2'b00, "R2 gate fall count low");
    apply(2'b01, 2'b00, "R3 count rise gate low");
    apply(2'b01, 2'b01, "R3 gate rise count high");
    apply(2'b01, 2'b00, "R3 gate fall count high");
    apply(2'b00, 2'b00, "R3 count fall gate low");
    apply(2'b10, 2'b10, "R7 other counter edge");

    // R4 clear with priority over a qualifying edge
    clr = 2'b01;
    apply(2'b11, 2'b11, "R4 clear beats edge");
    clr = 2'b00;
    settle();
    check_all("R4 after clear");
    apply(2'b00, 2'b11, "R3 fall under gate high");

    // R5 / R6 wrap
    clr = 2'b11; settle();
    for (int i = 0; i < 2; i++) begin m_bcd[i] = 0; m_bin[i] = 0; end
    check_all("R4 clear both");
    clr = 2'b00; settle();
    for (int k = 0; k < 10; k++) pulse0("R5 decimal run");
    chk("R5 decimal wrap to 0", int'(q_bcd[3:0]), 0);
    for (int k = 0; k < 6; k++) pulse0("R6 binary run");
    chk("R6 binary wrap to 0", int'(q_bin[3:0]), 0);

    // R7 random
    for (int s = 0; s < 400; s++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 4'd0) begin
        clr = r[9:8] | 2'b01;
        apply(c_drv, e_drv, "R4 random clear");
        clr = 2'b00;
      end else begin
        apply(c_drv ^ r[5:4], e_drv ^ r[7:6], "R7 random");
      end
    end

    // R8 cascade
    casc = 1'b1;
    c_drv = 2'b00; e_drv = 2'b01;
    clr = 2'b11; settle();
    for (int i = 0; i < 2; i++) begin m_bcd[i] = 0; m_bin[i] = 0; end
    clr = 2'b00; settle();
    check_all("R8 cascade start");
    for (int k = 0; k < 37; k++) pulse0("R8 cascade");
    chk("R8 decimal tens", int'(q_bcd[7:4]), 3);
    chk("R8 binary upper", int'(q_bin[7:4]), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule